// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Controller

This block is a register-mapped general-purpose I/O controller for sixteen pins. Each pin owns a four-bit setup word. The word selects whether the pin drives its pad, whether the sampled pad value is inverted, whether the pin may raise its interrupt line, and whether that interrupt is level-sensitive or a latched rising-edge event. Software changes the output latch through a set port and a clear port, each written with a bit mask. Because of this, one write never disturbs pins that the mask does not name, and no read-modify-write is needed.

Pad inputs are first resynchronised by two flops. They are then XORed with the per-pin invert bit, and the result feeds both the input read port and the interrupt logic. Each pin has its own interrupt output. In level mode that output follows the conditioned input. In edge mode a rising edge of the conditioned input sets a sticky pending bit, which software removes by writing a one to that pin's position in the interrupt-acknowledge port. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every pad output enable, every pad output value and every interrupt line is 0, and every setup word and the output latch read as 0.
- R2: Addresses 0x00 to 0x0F hold the setup word of the pin with the same index. Bit 0 is drive enable, bit 1 is input invert, bit 2 is interrupt enable and bit 3 is trigger select (0 = level, 1 = rising edge). Reads return these four bits with all higher bits 0. Any address not listed in R2, R4 or R5 reads as 0.
- R3: `pad_oe[i]` equals the drive-enable bit of pin i, and `pad_out` always presents the output latch.
- R4: A write to 0x10 sets every latch bit whose data bit is 1. A write to 0x11 clears every latch bit whose data bit is 1. Latch bits written with 0 keep their value. Address 0x14 reads the latch.
- R5: Address 0x14 is the output latch; address 0x13 reads the pad inputs after two synchronising flops, each XORed with its pin's invert bit. A pad change made before clock edge k is visible at 0x13 after edge k+1.
- R6: An interrupt line is never high while its pin's interrupt-enable bit is 0.
- R7: In level mode with interrupt enable set, the pin's interrupt line equals its conditioned input with no latching. It falls as soon as the conditioned input falls.
- R8: In edge mode, a 0-to-1 change of the conditioned input sets the pin's pending bit. The bit stays set until a write to 0x12 with a 1 in that pin's position. Positions written with 0 are unaffected. With interrupt enable set, the line shows the pending bit.
- R9: If a rising edge of a pin's conditioned input and an acknowledge write for that pin land on the same clock edge, the pending bit stays set.
- R10: Edge detection acts on the conditioned value. With invert set, a falling pad edge raises the pending bit and a rising pad edge does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Output latch values |
| pad_oe | output | 16 | Per-pin drive enable |
| irq | output | 16 | Per-pin interrupt lines |

## Verification
Some internal faults stay hidden at the ports. A corrupted pending bit is one example: it shows nowhere until the pin is put in edge mode with interrupt enable set, and from then on it appears on that pin's interrupt line at the next clock edge. A lost latch bit, by contrast, appears on `pad_out` immediately. A wrong synchroniser depth or a missing invert stage shows as an input read or a level interrupt that arrives one cycle early or late, or has the wrong polarity. For these reasons the bench samples each input-driven result at the exact edge count the requirements give, and not merely "eventually". The acknowledge/edge collision is driven cycle-exactly, because a wrong merge order there loses the event silently: the only symptom is a missing interrupt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS_DEF  = 16;
    localparam int ADDR_W_DEF = 5;
    localparam int CFG_W      = 4;

    // Setup word, drive enable in bit 0 (first member is the MSB)
    typedef struct packed {
        logic trig_edge;
        logic int_en;
        logic invert;
        logic drive_en;
    } pin_setup_t;

    localparam logic [ADDR_W_DEF-1:0] ADR_OUT_SET = 5'h10;
    localparam logic [ADDR_W_DEF-1:0] ADR_OUT_CLR = 5'h11;
    localparam logic [ADDR_W_DEF-1:0] ADR_ACK     = 5'h12;
    localparam logic [ADDR_W_DEF-1:0] ADR_IN_RD   = 5'h13;
    localparam logic [ADDR_W_DEF-1:0] ADR_OUT_RD  = 5'h14;

    function automatic logic is_setup_addr(input logic [ADDR_W_DEF-1:0] a,
                                           input logic [ADDR_W_DEF-1:0] limit);
        return a < limit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cond_in,
    input  pin_setup_t setup,
    input  logic       ack,
    output logic       pending,
    output logic       irq
);
    logic last_in;
    logic rise;

    assign rise = cond_in & ~last_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_in <= 1'b0;
            pending <= 1'b0;
        end else begin
            last_in <= cond_in;
            // a new edge wins over an acknowledge in the same cycle
            pending <= (pending & ~ack) | (rise & setup.trig_edge);
        end
    end

    assign irq = setup.int_en & (setup.trig_edge ? pending : cond_in);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS  = NPINS_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [NPINS-1:0]       bus_wdata,
    input  logic [NPINS-1:0]       cond_in,
    output pin_setup_t [NPINS-1:0] setup_q,
    output logic [NPINS-1:0]       out_q,
    output logic [NPINS-1:0]       ack_mask,
    output logic [NPINS-1:0]       bus_rdata
);
    localparam int IDX_W = $clog2(NPINS);
    localparam logic [ADDR_W-1:0] SETUP_LIMIT = ADDR_W'(NPINS);

    logic             hit_setup;
    logic [IDX_W-1:0] idx;

    assign hit_setup = is_setup_addr(bus_addr, SETUP_LIMIT);
    assign idx       = bus_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
            out_q   <= '0;
        end else if (bus_wr) begin
            if (hit_setup) begin
                setup_q[idx] <= pin_setup_t'(bus_wdata[CFG_W-1:0]);
            end else begin
                case (bus_addr)
                    ADR_OUT_SET: out_q <= out_q | bus_wdata;
                    ADR_OUT_CLR: out_q <= out_q & ~bus_wdata;
                    default:     ;
                endcase
            end
        end
    end

    assign ack_mask = (bus_wr && bus_addr == ADR_ACK) ? bus_wdata : '0;

    always_comb begin
        bus_rdata = '0;
        if (hit_setup) begin
            bus_rdata[CFG_W-1:0] = setup_q[idx];
        end else begin
            case (bus_addr)
                ADR_IN_RD:  bus_rdata = cond_in;
                ADR_OUT_RD: bus_rdata = out_q;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS  = NPINS_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  irq
);
    pin_setup_t [NPINS-1:0] setup_q;
    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] cond_in;
    logic [NPINS-1:0] inv_vec;
    logic [NPINS-1:0] ie_vec;
    logic [NPINS-1:0] edge_vec;
    logic [NPINS-1:0] pend_vec;
    logic [NPINS-1:0] ack_mask;
    logic [NPINS-1:0] out_q;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cond_in   (cond_in),
        .setup_q   (setup_q),
        .out_q     (out_q),
        .ack_mask  (ack_mask),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pad_oe[i]   = setup_q[i].drive_en;
        assign inv_vec[i]  = setup_q[i].invert;
        assign ie_vec[i]   = setup_q[i].int_en;
        assign edge_vec[i] = setup_q[i].trig_edge;

        gpio_pin_irq u_irq (
            .clk     (clk),
            .rst     (rst),
            .cond_in (cond_in[i]),
            .setup   (setup_q[i]),
            .ack     (ack_mask[i]),
            .pending (pend_vec[i]),
            .irq     (irq[i])
        );
    end

    assign cond_in = sync_in ^ inv_vec;
    assign pad_out = out_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPINS  = NPINS_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  irq,
    input logic [NPINS-1:0]  ie_vec,
    input logic [NPINS-1:0]  edge_vec,
    input logic [NPINS-1:0]  cond_in,
    input logic [NPINS-1:0]  pend_vec
);
    logic             wr_set, wr_clr;
    logic [NPINS-1:0] ack_bits;
    logic [NPINS-1:0] prev_cond;
    logic [NPINS-1:0] race_bits;

    assign wr_set    = bus_wr && bus_addr == ADR_OUT_SET;
    assign wr_clr    = bus_wr && bus_addr == ADR_OUT_CLR;
    assign ack_bits  = (bus_wr && bus_addr == ADR_ACK) ? bus_wdata : '0;
    assign race_bits = ack_bits & edge_vec & cond_in & ~prev_cond;

    always_ff @(posedge clk) begin
        if (rst) prev_cond <= '0;
        else     prev_cond <= cond_in;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (irq & ~ie_vec) == '0); // R6

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata))); // R4

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((pad_out & $past(bus_wdata)) == '0)); // R4

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wr_set && !wr_clr) |=> $stable(pad_out)); // R4

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (irq & ~edge_vec) == (cond_in & ie_vec & ~edge_vec)); // R7

    AST_EDGE_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
        (irq & edge_vec & ~pend_vec) == '0); // R8

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend_vec != '0) |=> (($past(pend_vec) & ~$past(ack_bits) & ~pend_vec) == '0)); // R8

    AST_ACK_RACE: assert property (@(posedge clk) disable iff (rst)
        (race_bits != '0) |=> ((pend_vec & $past(race_bits)) == $past(race_bits))); // R9

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .irq       (irq),
    .ie_vec    (ie_vec),
    .edge_vec  (edge_vec),
    .cond_in   (cond_in),
    .pend_vec  (pend_vec)
);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
    import gpio_pkg::*;

    localparam int NP = 16;
    localparam int AW = 5;

    typedef enum int {K_RD, K_IRQ, K_OUT, K_OE} kind_t;
    typedef struct {
        kind_t          kind;
        logic [AW-1:0]  addr;
        logic [NP-1:0]  exp;
        string          tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];
    event  mon_ev, mon_done;

    always #2 clk = ~clk;

    gpio_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [NP-1:0] act;
            @(mon_ev);
            #1;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = irq;
                K_OUT:   act = pad_out;
                default: act = pad_oe;
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                         it.tag, it.kind, it.addr, act, it.exp);
            end
            ->mon_done;
        end
    end

    task automatic expect_item(kind_t k, logic [AW-1:0] a, logic [NP-1:0] e, string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = k; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->mon_ev;
        @(mon_done);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pad(logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    initial begin
        cyc(4);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        expect_item(K_OE,  '0, 16'h0000, "R1 pad_oe");
        expect_item(K_OUT, '0, 16'h0000, "R1 pad_out");
        expect_item(K_IRQ, '0, 16'h0000, "R1 irq");
        expect_item(K_RD, 5'h00, 16'h0000, "R1 setup0");
        expect_item(K_RD, ADR_OUT_RD, 16'h0000, "R1 latch");

        // R2 setup readback, R3 drive enable
        wr(5'h03, 16'h001F);
        expect_item(K_RD, 5'h03, 16'h000F, "R2 setup3");
        expect_item(K_OE, '0, 16'h0008, "R3 pad_oe");
        wr(5'h03, 16'h0001);
        wr(ADR_ACK, 16'h0008);
        expect_item(K_RD, 5'h03, 16'h0001, "R2 setup3 rewrite");
        expect_item(K_RD, 5'h1F, 16'h0000, "R2 unmapped");

        // R4 set/clear
        wr(ADR_OUT_SET, 16'h0009);
        expect_item(K_RD, ADR_OUT_RD, 16'h0009, "R4 after set");
        expect_item(K_OUT, '0, 16'h0009, "R3 pad_out");
        wr(ADR_OUT_CLR, 16'h0001);
        expect_item(K_RD, ADR_OUT_RD, 16'h0008, "R4 after clear");
        wr(ADR_OUT_SET, 16'h0000);
        wr(ADR_OUT_CLR, 16'h0000);
        expect_item(K_RD, ADR_OUT_RD, 16'h0008, "R4 zero masks");

        // R5 input read and inversion
        set_pad(16'h00F0);
        cyc(1);
        expect_item(K_RD, ADR_IN_RD, 16'h00F0, "R5 sync input");
        wr(5'h04, 16'h0002);
        expect_item(K_RD, ADR_IN_RD, 16'h00E0, "R5 inverted pin4");

        // R7 level mode, R6 gating
        wr(5'h05, 16'h0004);
        expect_item(K_IRQ, '0, 16'h0020, "R7 level high / R6 others gated");
        set_pad(16'h00D0);
        cyc(1);
        expect_item(K_IRQ, '0, 16'h0000, "R7 level falls");
        set_pad(16'h00F0);
        cyc(1);
        expect_item(K_IRQ, '0, 16'h0020, "R7 level rises again");
        wr(5'h05, 16'h0000);
        expect_item(K_IRQ, '0, 16'h0000, "R6 enable cleared");

        // R8 edge mode sticky pending
        wr(5'h08, 16'h000C);
        set_pad(16'h01F0);
        cyc(2);
        expect_item(K_IRQ, '0, 16'h0100, "R8 edge latched");
        set_pad(16'h00F0);
        cyc(2);
        expect_item(K_IRQ, '0, 16'h0100, "R8 sticky after pad low");
        wr(ADR_ACK, 16'h0000);
        expect_item(K_IRQ, '0, 16'h0100, "R8 zero ack ignored");
        wr(ADR_ACK, 16'h0100);
        expect_item(K_IRQ, '0, 16'h0000, "R8 ack clears");

        // R10 edge on conditioned value
        wr(5'h09, 16'h0002);
        cyc(1);
        wr(5'h09, 16'h000E);
        cyc(2);
        expect_item(K_IRQ, '0, 16'h0000, "R10 no spurious pending");
        set_pad(16'h02F0);
        cyc(2);
        expect_item(K_IRQ, '0, 16'h0000, "R10 pad rise ignored");
        set_pad(16'h00F0);
        cyc(2);
        expect_item(K_IRQ, '0, 16'h0200, "R10 pad fall latches");
        wr(ADR_ACK, 16'h0200);
        expect_item(K_IRQ, '0, 16'h0000, "R10 ack");

        // R9 ack colliding with a new edge
        wr(5'h0A, 16'h000C);
        set_pad(16'h04F0);
        cyc(2);
        expect_item(K_IRQ, '0, 16'h0400, "R9 first edge");
        set_pad(16'h00F0);
        cyc(3);
        @(negedge clk); pad_in = 16'h04F0;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = ADR_ACK; bus_wdata = 16'h0400;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        expect_item(K_IRQ, '0, 16'h0400, "R9 edge beats ack");
        wr(ADR_ACK, 16'h0400);
        expect_item(K_IRQ, '0, 16'h0000, "R8 final ack");

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..: actual=hung expected=done");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule